// File: doc/BRIEF.md
# I2C Target with Per-Byte CRC-8

This block is the serial front end of a byte-addressed register file. It sits on a two-wire bus as a target, answers one programmable 7-bit address, and takes the first byte of a write as a register pointer. It then streams data bytes into the register file or out of it, and the pointer advances by one after every data byte. A read can follow the pointer write either through a repeated start or after a stop and a fresh start.

An optional CRC-8 guards every data byte. The generator polynomial is 0x07 and the initial value is zero. In writes the controller appends the check byte and the target verifies it. A mismatch is refused with a NACK, the byte is dropped, and the target stops listening until the next start. In reads the target appends the check byte, and a NACK on it ends the transfer. The first data byte's check value also covers the address phases of the transfer, which run across a repeated start but not across a stop. Later bytes are covered on their own.

The block samples SCL and SDA through synchronisers in its own clock domain and only ever pulls SDA low, which it signals through an output enable. It does not stretch the clock.

Top module: `i2c_crc_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `tgt_addr`. With `tgt_addr` = 0x08 these are bytes 0x10 (bit 0 = 0, write) and 0x11 (bit 0 = 1, read). Any other address is not acknowledged, and the rest of that transfer is ignored.
- R2: In a write, the byte after the address loads the register pointer. Each later data byte is written through a one-cycle `reg_we` pulse, with `reg_waddr` and `reg_wdata` valid during the pulse, and the pointer then increments.
- R3: In a read, each data byte is taken from `reg_rdata` at `reg_raddr` and sent MSB first, and the pointer then increments. This works with a repeated start and with a stop before the read address. With CRC off, a controller NACK on a data byte ends the transfer and SDA is released.
- R4: CRC mode is off after reset. The value on `crc_en` is adopted only when `cfg_update` falls, and while `cfg_update` is high the old mode stays in force.
- R5: With CRC on, a check byte follows every data byte. The check is CRC-8 with polynomial 0x07 and initial value 0, computed MSB first. The accumulator is cleared after each data byte's check byte and on every stop.
- R6: In a CRC write, the first data byte's check covers the write address byte, the register byte and the data byte, and each later byte's check covers only that byte. A correct check byte is acknowledged, and only then is the data byte written.
- R7: In a CRC write, a wrong check byte is not acknowledged and its data byte is not written. The target then ignores every byte until the next start.
- R8: In a CRC read after a repeated start, the first byte's check covers the write address byte, the register byte, the read address byte and the data. After a stop it covers only the read address byte and the data. Later bytes' checks cover only the data. With CRC on, the check byte is sent whatever the controller answered to the data byte.
- R9: In a CRC read, a controller NACK on a check byte returns the target to idle, and it leaves SDA released from then on.
- R10: A start condition at any point abandons the byte in progress and begins a new address byte.
- R11: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R12: During and after reset, `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| tgt_addr | input | 7 | 7-bit address the target answers |
| crc_en | input | 1 | Requested CRC mode |
| cfg_update | input | 1 | Configuration window; mode is adopted on its falling edge |
| reg_raddr | output | 8 | Register pointer for reads |
| reg_rdata | input | 8 | Register contents at `reg_raddr` |
| reg_waddr | output | 8 | Register address for a write |
| reg_wdata | output | 8 | Data for a write |
| reg_we | output | 1 | One-cycle write strobe |

## Verification
Two functions can act on the same SCL falling edge. One is the acknowledge or rejection of a write check byte; the other is the commit of the held data byte together with the pointer increment. A second such pair is the end of a read check byte and the fetch of the next register byte, whose value seeds a fresh CRC. The bench provokes both with block CRC writes, block CRC reads, a deliberately wrong check byte and NACKs placed on data and on check bytes. A reference model holds a queue of expected writes that is compared against the write port on every clock. The same model recomputes every check byte from its own record of the bytes on the bus.

// File: rtl/i2c_crc_target.sv
module i2c_crc_target (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] tgt_addr,
  input  logic       crc_en,
  input  logic       cfg_update,
  output logic [7:0] reg_raddr,
  input  logic [7:0] reg_rdata,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output logic       reg_we
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADR, S_REG, S_WDAT, S_WCRC, S_AACK, S_RDAT, S_RCRC, S_MACK
  } st_t;

  st_t        st, nxt;
  logic [2:0] scl_s, sda_s;
  logic [3:0] cnt;
  logic [7:0] sh, tx, crc, ptr, wbuf;
  logic       crc_on, cfg_upd_d, was_crc, mack;

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start    = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire stop     = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];
  wire byte_end = scl_fall && cnt == 4'd8;

  assign reg_raddr = ptr;

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[6:0], 1'b0} ^ ((r[7] ^ b[i]) ? 8'h07 : 8'h00);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      st <= S_IDLE; nxt <= S_IDLE;
      cnt <= '0; sh <= '0; tx <= '0; crc <= '0; ptr <= '0; wbuf <= '0;
      crc_on <= 1'b0; cfg_upd_d <= 1'b0; was_crc <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; reg_we <= 1'b0; reg_waddr <= '0; reg_wdata <= '0;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
      reg_we <= 1'b0;
      cfg_upd_d <= cfg_update;
      if (cfg_upd_d && !cfg_update) crc_on <= crc_en;

      if (start) begin
        st <= S_ADR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0; crc <= '0;
      end else begin
        case (st)
          S_ADR, S_REG, S_WDAT, S_WCRC: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_s[1]};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              case (st)
                S_ADR:
                  if (sh[7:1] == tgt_addr) begin
                    crc <= crc_upd(crc, sh);
                    nxt <= sh[0] ? S_RDAT : S_REG;
                    sda_oe <= 1'b1; st <= S_AACK;
                  end else begin
                    st <= S_IDLE; crc <= '0;
                  end
                S_REG: begin
                  ptr <= sh; crc <= crc_upd(crc, sh);
                  nxt <= S_WDAT; sda_oe <= 1'b1; st <= S_AACK;
                end
                S_WDAT: begin
                  if (crc_on) begin
                    wbuf <= sh; crc <= crc_upd(crc, sh); nxt <= S_WCRC;
                  end else begin
                    reg_we <= 1'b1; reg_waddr <= ptr; reg_wdata <= sh;
                    ptr <= ptr + 8'd1; nxt <= S_WDAT;
                  end
                  sda_oe <= 1'b1; st <= S_AACK;
                end
                default:
                  if (sh == crc) begin
                    reg_we <= 1'b1; reg_waddr <= ptr; reg_wdata <= wbuf;
                    ptr <= ptr + 8'd1; crc <= '0;
                    nxt <= S_WDAT; sda_oe <= 1'b1; st <= S_AACK;
                  end else begin
                    st <= S_IDLE; crc <= '0;
                  end
              endcase
            end
          end
          S_AACK:
            if (scl_fall) begin
              if (nxt == S_RDAT) begin
                tx <= reg_rdata; sda_oe <= ~reg_rdata[7];
                crc <= crc_upd(crc, reg_rdata); ptr <= ptr + 8'd1; cnt <= 4'd1;
              end else begin
                sda_oe <= 1'b0; cnt <= '0;
              end
              st <= nxt;
            end
          S_RDAT, S_RCRC:
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; cnt <= '0;
                was_crc <= (st == S_RCRC); st <= S_MACK;
              end else begin
                sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 4'd1;
              end
            end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_s[1];
            if (scl_fall) begin
              if (crc_on && !was_crc) begin
                tx <= crc; sda_oe <= ~crc[7]; crc <= '0; cnt <= 4'd1; st <= S_RCRC;
              end else if (mack) begin
                tx <= reg_rdata; sda_oe <= ~reg_rdata[7];
                crc <= crc_upd(crc, reg_rdata); ptr <= ptr + 8'd1; cnt <= 4'd1;
                st <= S_RDAT;
              end else begin
                st <= S_IDLE; crc <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_sda_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s[1]));

  assert_we_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_crc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> crc == 8'h00);

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_upd_d && !cfg_update) |=> $stable(crc_on));

  assert_badcrc_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WCRC && byte_end && sh != crc) |=> (!reg_we && st == S_IDLE));

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);

endmodule

// File: tb/i2c_crc_target_test.sv
module i2c_crc_target_test;
  localparam int CLK_P = 10;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic hscl = 1, hs = 1;
  logic [6:0] tgt_addr = 7'h08;
  logic crc_en = 0, cfg_update = 0;
  logic sda_oe, reg_we;
  logic [7:0] reg_raddr, reg_rdata, reg_waddr, reg_wdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] wq [$];
  int checks = 0, fails = 0, glitches = 0;
  logic oe_q = 0, scl_q = 1;

  wire sda_line = hs & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2c_crc_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(hscl), .sda_i(sda_line), .sda_oe(sda_oe),
    .tgt_addr(tgt_addr), .crc_en(crc_en), .cfg_update(cfg_update),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_we(reg_we));

  assign reg_rdata = mem[reg_raddr];
  always @(posedge clk) if (reg_we) mem[reg_waddr] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_q && hscl && scl_q) glitches++;
    oe_q <= sda_oe; scl_q <= hscl;
    if (rst_n && reg_we) begin
      if (wq.size() == 0) chk(0, "R2 unexpected write", {reg_waddr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = wq.pop_front();
        chk({reg_waddr, reg_wdata} == e, "R2 write port", {reg_waddr, reg_wdata}, e);
      end
    end
  end

  function automatic logic [7:0] c8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic tk(input int n); repeat (n) @(negedge clk); endtask

  task automatic st_c();
    hs = 1; tk(H); hscl = 1; tk(H); hs = 0; tk(H); hscl = 0; tk(2);
  endtask

  task automatic sp_c();
    hs = 0; tk(H); hscl = 1; tk(H); hs = 1; tk(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      hs = b[i]; tk(H); hscl = 1; tk(H); hscl = 0; tk(2);
    end
    hs = 1; tk(H); hscl = 1; tk(H/2); ack = !sda_line; tk(H/2); hscl = 0; tk(2);
  endtask

  task automatic rd_byte(output logic [7:0] v, input bit ack);
    hs = 1; v = '0;
    for (int i = 0; i < 8; i++) begin
      tk(H); hscl = 1; tk(H/2); v = {v[6:0], sda_line}; tk(H/2); hscl = 0; tk(2);
    end
    hs = !ack; tk(H); hscl = 1; tk(H); hscl = 0; tk(2); hs = 1;
  endtask

  task automatic wb(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    wr_byte(b, a);
    chk(a == exp_ack, tag, a, exp_ack);
  endtask

  task automatic rb(input logic [7:0] e, input bit ack, input string tag);
    logic [7:0] v;
    rd_byte(v, ack);
    chk(v == e, tag, v, e);
  endtask

  task automatic mwr(input logic [7:0] a, input logic [7:0] d);
    exp_mem[a] = d; wq.push_back({a, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] c;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    tk(5);
    chk(sda_oe == 0 && reg_we == 0, "R12 in reset", {sda_oe, reg_we}, 0);
    rst_n = 1; tk(5);
    chk(sda_oe == 0 && reg_we == 0, "R12 after reset", {sda_oe, reg_we}, 0);

    // single write, CRC off by default
    st_c(); wb(8'h10, 1, "R1 write address ack"); wb(8'h20, 1, "R2 reg ack");
    mwr(8'h20, 8'h5A); wb(8'h5A, 1, "R2 data ack"); sp_c();

    // block write, auto increment
    st_c(); wb(8'h10, 1, "R2"); wb(8'h30, 1, "R2");
    mwr(8'h30, 8'h11); wb(8'h11, 1, "R2 block");
    mwr(8'h31, 8'h22); wb(8'h22, 1, "R2 block");
    mwr(8'h32, 8'h33); wb(8'h33, 1, "R2 block"); sp_c();

    // read with repeated start
    st_c(); wb(8'h10, 1, "R3"); wb(8'h31, 1, "R3"); st_c();
    wb(8'h11, 1, "R1 read address ack"); rb(exp_mem[8'h31], 0, "R3 rstart read"); sp_c();

    // block read after stop, NACK ends it
    st_c(); wb(8'h10, 1, "R3"); wb(8'h30, 1, "R3"); sp_c();
    st_c(); wb(8'h11, 1, "R3");
    rb(exp_mem[8'h30], 1, "R3 block read"); rb(exp_mem[8'h31], 1, "R3 block read");
    rb(exp_mem[8'h32], 0, "R3 block read last");
    rb(8'hFF, 0, "R3 released after NACK"); sp_c();

    // wrong address, then a different programmed address
    st_c(); wb(8'h12, 0, "R1 foreign address NACK"); wb(8'h20, 0, "R1 ignored"); sp_c();
    tgt_addr = 7'h2A; tk(2);
    st_c(); wb(8'h54, 1, "R1 programmed address"); wb(8'h40, 1, "R1");
    mwr(8'h40, 8'h77); wb(8'h77, 1, "R1 data"); sp_c();
    tgt_addr = 7'h08; tk(2);

    // CRC requested but not adopted while cfg_update is high
    crc_en = 1; cfg_update = 1; tk(4);
    st_c(); wb(8'h10, 1, "R4"); wb(8'h21, 1, "R4");
    mwr(8'h21, 8'h66); wb(8'h66, 1, "R4 mode held"); sp_c();
    cfg_update = 0; tk(4);

    // CRC single write
    st_c(); wb(8'h10, 1, "R6"); wb(8'h50, 1, "R6"); wb(8'hA5, 1, "R6 data");
    c = c8(c8(c8(8'h00, 8'h10), 8'h50), 8'hA5);
    mwr(8'h50, 8'hA5); wb(c, 1, "R6 first byte check ack"); sp_c();

    // CRC block write
    st_c(); wb(8'h10, 1, "R6"); wb(8'h60, 1, "R6"); wb(8'hC3, 1, "R6");
    mwr(8'h60, 8'hC3); wb(c8(c8(c8(8'h00, 8'h10), 8'h60), 8'hC3), 1, "R6 block first check");
    wb(8'h3C, 1, "R6");
    mwr(8'h61, 8'h3C); wb(c8(8'h00, 8'h3C), 1, "R5 later check data only"); sp_c();

    // bad CRC
    st_c(); wb(8'h10, 1, "R7"); wb(8'h70, 1, "R7"); wb(8'h99, 1, "R7");
    c = c8(c8(c8(8'h00, 8'h10), 8'h70), 8'h99);
    wb(c ^ 8'h01, 0, "R7 bad check NACK"); wb(8'h99, 0, "R7 idle after bad check"); sp_c();

    // CRC read with repeated start, block
    st_c(); wb(8'h10, 1, "R8"); wb(8'h60, 1, "R8"); st_c(); wb(8'h11, 1, "R8");
    rb(8'hC3, 1, "R8 data");
    rb(c8(c8(c8(c8(8'h00, 8'h10), 8'h60), 8'h11), 8'hC3), 1, "R8 rstart first check");
    rb(8'h3C, 1, "R8 second data");
    rb(c8(8'h00, 8'h3C), 0, "R8 later check data only");
    rb(8'hFF, 0, "R9 released after check NACK"); sp_c();

    // CRC read after stop, data NACK ignored
    st_c(); wb(8'h10, 1, "R8"); wb(8'h50, 1, "R8"); sp_c();
    st_c(); wb(8'h11, 1, "R8");
    rb(8'hA5, 0, "R8 data");
    rb(c8(c8(8'h00, 8'h11), 8'hA5), 0, "R8 check after stop follows NACKed data"); sp_c();

    // rejected byte was not written
    st_c(); wb(8'h10, 1, "R7"); wb(8'h70, 1, "R7"); st_c(); wb(8'h11, 1, "R7");
    rb(8'h00, 1, "R7 rejected byte absent");
    rb(c8(c8(c8(c8(8'h00, 8'h10), 8'h70), 8'h11), 8'h00), 0, "R7 check"); sp_c();

    // start aborts a partial address byte
    st_c();
    for (int i = 7; i >= 5; i--) begin hs = 1'b0; tk(H); hscl = 1; tk(H); hscl = 0; tk(2); end
    st_c(); wb(8'h10, 1, "R10 restart address"); wb(8'h22, 1, "R10"); wb(8'h44, 1, "R10");
    mwr(8'h22, 8'h44); wb(c8(c8(c8(8'h00, 8'h10), 8'h22), 8'h44), 1, "R10 check after abort");
    sp_c();

    tk(10);
    chk(wq.size() == 0, "R2 all expected writes seen", wq.size(), 0);
    chk(glitches == 0, "R11 sda_oe steady while SCL high", glitches, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule